// File: doc/BRIEF.md
# Card Function Configuration Register Set

This block holds the configuration registers of one card function and lets the host read and write them one byte at a time over attribute space. The register window begins at a base address supplied on a configuration input. Registers exist only at even offsets from that base, and data travels on the low byte. The host selects a configuration by writing its table index into the option register. A nonzero index enables the function. A soft-reset bit in the same register holds the function in reset.

The block drives four outputs to the function logic: an enable, a level-or-pulse interrupt mode, a soft reset, and the card's active-low interrupt line. The interrupt line is shaped from the function's interrupt source. In level mode the line follows the source. In pulse mode each new event gives a low pulse of fixed width. The window holds the option register, a status register, three plain storage registers and a parameterised number of I/O base bytes.

Top module: `fcfg_regs`

## Requirements
- R1: While the active-low hard reset is asserted, and after it is released with no writes, every register reads 0x00, `func_en` and `func_rst` are 0, `func_lvl` is 0 and `irq_n` is 1.
- R2: The register at index k sits at byte offset 2*k from `cfg_base`. With four I/O bases the offsets are 0x00 option, 0x02 status, 0x04 pin replacement, 0x06 socket/copy, 0x08 extended status, and 0x0A, 0x0C, 0x0E, 0x10 for I/O bases 0 to 3. A write updates the register at the clock edge that samples `host_wr`. `host_rdata` shows the addressed value from the edge that samples `host_rd`, and holds that value until the next read.
- R3: An access to an odd offset, to an offset past the last register, or to an address below `cfg_base` changes no register. A read of such an address returns 0x00.
- R4: The option byte holds the configuration index in bits 5:0, the level-mode select in bit 6 and soft reset in bit 7. `func_en` is 1 exactly while the stored index is nonzero, starting at the edge that takes the write.
- R5: A write to the option register with bit 7 set asserts `func_rst`, stores the index as zero and forces `func_en` low. The option register then reads back with bit 7 set and bits 5:0 zero. A later write with bit 7 clear releases `func_rst` and stores the new index.
- R6: `func_lvl` equals option bit 6. In level mode (bit 6 = 1), with the function enabled, `irq_n` goes low one clock after an edge that samples `irq_src` high. It returns high one clock after an edge that samples `irq_src` low.
- R7: In pulse mode (bit 6 = 0), with the function enabled, an edge that samples a rising `irq_src` drives `irq_n` low for exactly PULSE_W clocks. Holding `irq_src` high gives no further pulse.
- R8: While the function is not enabled, `irq_n` stays high whatever `irq_src` does.
- R9: Status bit 1 is read-only and reads the current `irq_src`. Writes to that bit are dropped. The other status bits are ordinary storage.
- R10: Changing `cfg_base` moves the whole window. The stored values then read at the new offsets, and the old addresses miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Card hard reset, active low, asynchronous |
| cfg_base | input | ADDR_W | Attribute address of the window start |
| host_addr | input | ADDR_W | Host attribute address |
| host_wdata | input | 8 | Host write byte |
| host_wr | input | 1 | Write strobe, one clock per access |
| host_rd | input | 1 | Read strobe, one clock per access |
| host_rdata | output | 8 | Registered read byte |
| irq_src | input | 1 | Interrupt request from the function, active high |
| func_en | output | 1 | Function enabled (nonzero index) |
| func_rst | output | 1 | Soft reset to the function |
| func_lvl | output | 1 | Interrupt mode: 1 level, 0 pulse |
| irq_n | output | 1 | Card interrupt, active low |

## Verification
The hardest case to reach is the interaction between soft reset and the stored index. The bench first enables the function with a nonzero index. It then writes an option byte that has both the reset bit and a nonzero index. It checks that the readback drops the index and that the enable falls. It then clears the reset bit with a different index and checks that the new index, not the old one, takes effect. A second hard case is the exact pulse width on `irq_n`. The bench counts falling-edge samples cycle by cycle while the source is held high, so both a short pulse and a retrigger would show.

// File: rtl/fcfg_pkg.sv
package fcfg_pkg;

   localparam int BYTE_W      = 8;
   localparam int IDX_W       = 6;

   // register indices inside the window (offset = 2 * index)
   localparam int RI_OPTION   = 0;
   localparam int RI_STATUS   = 1;
   localparam int RI_PINREP   = 2;
   localparam int RI_SOCKET   = 3;
   localparam int RI_EXTSTAT  = 4;
   localparam int RI_IOBASE0  = 5;

   // bit positions that neighbours decode
   localparam int STAT_IRQ_BIT = 1;

   typedef struct packed {
      logic             srst;
      logic             lvl;
      logic [IDX_W-1:0] idx;
   } opt_t;

endpackage

// File: rtl/fcfg_decode.sv
module fcfg_decode #(
   parameter int ADDR_W  = 12,
   parameter int REG_CNT = 9
) (
   input  logic [ADDR_W-1:0]  base,
   input  logic [ADDR_W-1:0]  addr,
   output logic               hit,
   output logic [REG_CNT-1:0] sel
);

   localparam int SLOT_W = ADDR_W - 1;

   logic [ADDR_W-1:0] rel;
   logic [SLOT_W-1:0] slot;
   logic              in_range;

   // addresses below base wrap to large offsets and miss
   assign rel      = addr - base;
   assign slot     = rel[ADDR_W-1:1];
   assign in_range = (slot < SLOT_W'(REG_CNT));
   assign hit      = in_range && !rel[0];

   for (genvar k = 0; k < REG_CNT; k++) begin : g_sel
      assign sel[k] = hit && (slot == SLOT_W'(k));
   end

endmodule

// File: rtl/fcfg_option.sv
module fcfg_option
   import fcfg_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] opt_rd,
   output logic              func_en,
   output logic              func_rst,
   output logic              func_lvl
);

   opt_t opt_q;
   opt_t opt_wr;

   always_comb begin
      opt_wr = opt_t'(wdata);
      if (opt_wr.srst) begin
         opt_wr.idx = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         opt_q <= '0;
      end else if (wr_en) begin
         opt_q <= opt_wr;
      end
   end

   assign opt_rd   = BYTE_W'(opt_q);
   assign func_en  = (opt_q.idx != '0);
   assign func_rst = opt_q.srst;
   assign func_lvl = opt_q.lvl;

   AST_SRST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wdata[BYTE_W-1]) |=> (func_rst && !func_en)); // R5

   AST_IDX_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wdata[BYTE_W-1] && (wdata[IDX_W-1:0] != '0)) |=> func_en); // R4

endmodule

// File: rtl/fcfg_irq.sv
module fcfg_irq #(
   parameter int PULSE_W = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic lvl_mode,
   input  logic src,
   output logic irq_n
);

   localparam int CNT_W = $clog2(PULSE_W + 1);

   logic             src_q;
   logic             lvl_q;
   logic [CNT_W-1:0] cnt_q;
   logic             rise;

   assign rise = src && !src_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q <= 1'b0;
         lvl_q <= 1'b0;
         cnt_q <= '0;
      end else begin
         src_q <= src;
         lvl_q <= en && src;
         if (!en || lvl_mode) begin
            cnt_q <= '0;
         end else if (rise) begin
            cnt_q <= CNT_W'(PULSE_W);
         end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - CNT_W'(1);
         end
      end
   end

   assign irq_n = lvl_mode ? !lvl_q : (cnt_q == '0);

   AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!en) |=> irq_n); // R8

   AST_LEVEL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_mode && en && src) |=> (!lvl_mode || !irq_n)); // R6

   if (PULSE_W > 1) begin : g_pulse_chk
      AST_PULSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
         ($fell(irq_n) && !lvl_mode && en) |=> (!irq_n || lvl_mode || !en)); // R7
   end

endmodule

// File: rtl/fcfg_regs.sv
module fcfg_regs
   import fcfg_pkg::*;
#(
   parameter int ADDR_W     = 12,
   parameter int NUM_IOBASE = 4,
   parameter int PULSE_W    = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cfg_base,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic [7:0]        host_wdata,
   input  logic              host_wr,
   input  logic              host_rd,
   output logic [7:0]        host_rdata,
   input  logic              irq_src,
   output logic              func_en,
   output logic              func_rst,
   output logic              func_lvl,
   output logic              irq_n
);

   localparam int REG_CNT    = RI_IOBASE0 + NUM_IOBASE;
   localparam int NUM_STORE  = REG_CNT - 1;
   localparam int SPAN_BITS  = $clog2(2 * REG_CNT);
   localparam logic [BYTE_W-1:0] STAT_WMASK = ~(BYTE_W'(1) << STAT_IRQ_BIT);

   if (NUM_IOBASE < 1 || NUM_IOBASE > 4) begin : g_bad_iobase
      $error("NUM_IOBASE must lie in 1..4");
   end
   if (ADDR_W <= SPAN_BITS) begin : g_bad_addr
      $error("ADDR_W too narrow for the register window");
   end
   if (PULSE_W < 1) begin : g_bad_pulse
      $error("PULSE_W must be at least 1");
   end

   logic                               hit;
   logic [REG_CNT-1:0]                 sel;
   logic [BYTE_W-1:0]                  opt_rd;
   logic [NUM_STORE-1:0][BYTE_W-1:0]   store_q;
   logic [REG_CNT-1:0][BYTE_W-1:0]     rd_view;
   logic [BYTE_W-1:0]                  rd_mux;

   fcfg_decode #(
      .ADDR_W  (ADDR_W),
      .REG_CNT (REG_CNT)
   ) u_decode (
      .base (cfg_base),
      .addr (host_addr),
      .hit  (hit),
      .sel  (sel)
   );

   fcfg_option u_option (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (host_wr && sel[RI_OPTION]),
      .wdata    (host_wdata),
      .opt_rd   (opt_rd),
      .func_en  (func_en),
      .func_rst (func_rst),
      .func_lvl (func_lvl)
   );

   fcfg_irq #(
      .PULSE_W (PULSE_W)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (func_en),
      .lvl_mode (func_lvl),
      .src      (irq_src),
      .irq_n    (irq_n)
   );

   // plain byte registers: status, pin replacement, socket, extended, I/O bases
   for (genvar k = 1; k < REG_CNT; k++) begin : g_store
      logic [BYTE_W-1:0] wmask;
      if (k == RI_STATUS) begin : g_stat
         assign wmask = STAT_WMASK;
         assign rd_view[k] = store_q[k-1] |
                             (BYTE_W'(irq_src) << STAT_IRQ_BIT);
      end else begin : g_plain
         assign wmask = '1;
         assign rd_view[k] = store_q[k-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            store_q[k-1] <= '0;
         end else if (host_wr && sel[k]) begin
            store_q[k-1] <= host_wdata & wmask;
         end
      end
   end

   assign rd_view[RI_OPTION] = opt_rd;

   always_comb begin
      rd_mux = '0;
      for (int k = 0; k < REG_CNT; k++) begin
         if (sel[k]) begin
            rd_mux = rd_mux | rd_view[k];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd) begin
         host_rdata <= rd_mux;
      end
   end

   AST_MISS_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && !hit) |=> (host_rdata == '0)); // R3

   AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_wr && !hit) |=> ($stable(store_q) && $stable(opt_rd))); // R3

   AST_STATUS_BIT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (host_rd && sel[RI_STATUS]) |=> (host_rdata[STAT_IRQ_BIT] == $past(irq_src))); // R9

endmodule

// File: tb/fcfg_regs_tb.sv
module fcfg_regs_tb;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 12;
   localparam int PULSE_W    = 4;
   localparam int NREG       = 9;
   localparam logic [ADDR_W-1:0] BASE_A = 12'h200;
   localparam logic [ADDR_W-1:0] BASE_B = 12'h340;

   logic              clk = 1'b0;
   logic              rst_n;
   logic [ADDR_W-1:0] cfg_base;
   logic [ADDR_W-1:0] host_addr;
   logic [7:0]        host_wdata;
   logic              host_wr;
   logic              host_rd;
   logic [7:0]        host_rdata;
   logic              irq_src;
   logic              func_en;
   logic              func_rst;
   logic              func_lvl;
   logic              irq_n;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fcfg_regs #(
      .ADDR_W     (ADDR_W),
      .NUM_IOBASE (4),
      .PULSE_W    (PULSE_W)
   ) u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cfg_base   (cfg_base),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .host_wr    (host_wr),
      .host_rd    (host_rd),
      .host_rdata (host_rdata),
      .irq_src    (irq_src),
      .func_en    (func_en),
      .func_rst   (func_rst),
      .func_lvl   (func_lvl),
      .irq_n      (irq_n)
   );

   task automatic check(input string req, input string what,
                        input int actual, input int expected);
      n_checks++;
      if (actual != expected) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, actual, expected);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
      @(negedge clk);
      host_addr = a; host_rd = 1'b1;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   function automatic logic [7:0] pattern(input int k);
      return 8'(8'h35 + 8'(k * 8'h1d));
   endfunction

   // R1: reset state
   task automatic t_reset_state();
      logic [7:0] d;
      check("R1", "func_en", int'(func_en), 0);
      check("R1", "func_rst", int'(func_rst), 0);
      check("R1", "func_lvl", int'(func_lvl), 0);
      check("R1", "irq_n", int'(irq_n), 1);
      for (int k = 0; k < NREG; k++) begin
         rd(BASE_A + ADDR_W'(2*k), d);
         check("R1", "reg after reset", int'(d), 0);
      end
   endtask

   // R2 and R9: map of the plain registers
   task automatic t_map_rw();
      logic [7:0] d;
      for (int k = 1; k < NREG; k++) wr(BASE_A + ADDR_W'(2*k), pattern(k));
      for (int k = 1; k < NREG; k++) begin
         rd(BASE_A + ADDR_W'(2*k), d);
         if (k == 1) check("R9", "status masked bit1", int'(d), int'(pattern(k) & 8'hfd));
         else        check("R2", "register readback", int'(d), int'(pattern(k)));
      end
   endtask

   // R9: status bit1 reflects the source
   task automatic t_status();
      logic [7:0] d;
      @(negedge clk); irq_src = 1'b1;
      rd(BASE_A + 2, d);
      check("R9", "status with src high", int'(d), int'(pattern(1) | 8'h02));
      @(negedge clk); irq_src = 1'b0;
      rd(BASE_A + 2, d);
      check("R9", "status with src low", int'(d), int'(pattern(1) & 8'hfd));
   endtask

   // R3: odd, past-end and below-base accesses
   task automatic t_outside();
      logic [7:0] d;
      wr(BASE_A + 1, 8'hff);
      wr(BASE_A + 3, 8'hff);
      wr(BASE_A + ADDR_W'(2*NREG), 8'hff);
      wr(BASE_A - 2, 8'hff);
      check("R3", "func_en untouched", int'(func_en), 0);
      rd(BASE_A, d);
      check("R3", "option untouched", int'(d), 0);
      for (int k = 1; k < NREG; k++) begin
         rd(BASE_A + ADDR_W'(2*k), d);
         check("R3", "reg untouched", int'(d), int'(k == 1 ? pattern(k) & 8'hfd : pattern(k)));
      end
      rd(BASE_A + 1, d);
      check("R3", "odd read", int'(d), 0);
      rd(BASE_A + ADDR_W'(2*NREG), d);
      check("R3", "past-end read", int'(d), 0);
      rd(BASE_A - 2, d);
      check("R3", "below-base read", int'(d), 0);
   endtask

   // R4, R5: option fields and soft reset
   task automatic t_option();
      logic [7:0] d;
      wr(BASE_A, 8'h07);
      check("R4", "enable on nonzero idx", int'(func_en), 1);
      check("R6", "pulse mode flag", int'(func_lvl), 0);
      rd(BASE_A, d);
      check("R4", "option readback", int'(d), 8'h07);
      wr(BASE_A, 8'h00);
      check("R4", "disable on zero idx", int'(func_en), 0);
      wr(BASE_A, 8'h05);
      wr(BASE_A, 8'hc9);
      check("R5", "func_rst set", int'(func_rst), 1);
      check("R5", "enable dropped", int'(func_en), 0);
      check("R6", "level flag", int'(func_lvl), 1);
      rd(BASE_A, d);
      check("R5", "idx reads zero", int'(d), 8'hc0);
      wr(BASE_A, 8'h0a);
      check("R5", "func_rst released", int'(func_rst), 0);
      check("R5", "enable with new idx", int'(func_en), 1);
      rd(BASE_A, d);
      check("R5", "new idx readback", int'(d), 8'h0a);
   endtask

   // R6: level interrupt
   task automatic t_level();
      wr(BASE_A, 8'h41);
      @(negedge clk); irq_src = 1'b1;
      @(negedge clk);
      check("R6", "level low after one edge", int'(irq_n), 0);
      repeat (3) @(negedge clk);
      check("R6", "level still low", int'(irq_n), 0);
      irq_src = 1'b0;
      @(negedge clk);
      check("R6", "level released", int'(irq_n), 1);
   endtask

   // R7: pulse interrupt
   task automatic t_pulse();
      wr(BASE_A, 8'h01);
      @(negedge clk); irq_src = 1'b1;
      for (int i = 0; i < PULSE_W + 3; i++) begin
         @(negedge clk);
         check("R7", "pulse shape", int'(irq_n), (i < PULSE_W) ? 0 : 1);
      end
      irq_src = 1'b0;
      repeat (2) @(negedge clk);
      check("R7", "no pulse on fall", int'(irq_n), 1);
   endtask

   // R8: disabled function gives no interrupt
   task automatic t_disabled();
      wr(BASE_A, 8'h40);
      @(negedge clk); irq_src = 1'b1;
      repeat (3) @(negedge clk);
      check("R8", "level off while disabled", int'(irq_n), 1);
      irq_src = 1'b0;
      wr(BASE_A, 8'h00);
      @(negedge clk); irq_src = 1'b1;
      repeat (2) @(negedge clk);
      check("R8", "pulse off while disabled", int'(irq_n), 1);
      irq_src = 1'b0;
   endtask

   // R10: moving the window
   task automatic t_base_move();
      logic [7:0] d;
      wr(BASE_A, 8'h23);
      @(negedge clk); cfg_base = BASE_B;
      rd(BASE_B, d);
      check("R10", "option at new base", int'(d), 8'h23);
      rd(BASE_B + 12'h10, d);
      check("R10", "last I/O base at new base", int'(d), int'(pattern(8)));
      rd(BASE_A + 12'h04, d);
      check("R10", "old address misses", int'(d), 0);
      wr(BASE_B + 12'h0c, 8'h5a);
      rd(BASE_B + 12'h0c, d);
      check("R10", "write at new base", int'(d), 8'h5a);
   endtask

   // R1: hard reset mid-run
   task automatic t_hard_reset();
      logic [7:0] d;
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      check("R1", "en in reset", int'(func_en), 0);
      check("R1", "rdata in reset", int'(host_rdata), 0);
      rst_n = 1'b1;
      for (int k = 0; k < NREG; k++) begin
         rd(BASE_B + ADDR_W'(2*k), d);
         check("R1", "reg after hard reset", int'(d), 0);
      end
      check("R1", "irq_n after hard reset", int'(irq_n), 1);
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 20000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cfg_base = BASE_A; host_addr = '0; host_wdata = '0;
      host_wr = 1'b0; host_rd = 1'b0; irq_src = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_map_rw();
      t_status();
      t_outside();
      t_option();
      t_level();
      t_pulse();
      t_disabled();
      t_base_move();
      t_hard_reset();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule